// File: doc/BRIEF.md
# Two-Register Processor Core with Selectable Fetch Overrun Policy

This block is the control and datapath core of a small 16-bit processor with two working registers: an address register (A) and a data register (D). Instructions arrive on a fetch port and data moves on a separate load/store port. The core never writes to instruction memory. The core holds the program counter and decodes two instruction kinds: an immediate load into A, and a compute instruction. A compute instruction feeds D and either A or the data read word through a separately instantiated ALU. It then writes the result to any mix of A, D and memory, and may branch to the address held in A.

The program counter is one bit wider than the fetch address. A build-time parameter decides what happens when that top bit becomes set. In mirror mode the bit is simply not driven out, so fetching wraps back to word 0. In trap mode the core stops: the program counter, registers and memory writes freeze until a synchronous reset. The instruction set has no halt. A program finishes by branching to itself forever, and the trap policy catches programs that run off the end instead.

Top module: `tiny_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter, A and D to zero and clears the halted flag; in the first cycle after reset the fetch address is 0.
- R2: A word with bit 15 clear loads bits 14:0, zero-extended, into A. D is left unchanged, no memory write occurs, and the program counter advances by one. The all-zero word therefore only loads 0 into A.
- R3: In a word with bit 15 set, the first ALU operand is D. Bit 12 picks the second operand: A when 0, the data read word when 1. Bits 11:6 control the ALU, from high bit to low: clear x, invert x, clear y, invert y, add (1) or AND (0), invert result.
- R4: In a compute word, bit 5 writes the result to A, bit 4 to D and bit 3 to memory. A memory write raises the write enable in that cycle, with the address taken from the low bits of A before the instruction and the ALU result on the write data.
- R5: Compute bits 2, 1 and 0 branch on a negative, zero and positive (non-zero, non-negative) result. A branch is taken when any selected condition holds. A taken branch loads the program counter from A before the instruction; otherwise the counter advances by one. A two-word self-branch therefore holds the fetch address in a fixed loop.
- R6: The all-ones word writes the value 1 to A, D and memory at the old A, and branches unconditionally to the old A.
- R7: The fetch address is the low bits of the program counter. In mirror mode, stepping past the last word fetches word 0 next.
- R8: In trap mode, once the program counter's top bit becomes set, halted rises in the next cycle and stays high until reset. While halted, the program counter and registers hold and the write enable stays low.
- R9: In trap mode, a branch to an A value with the program counter's top bit set also traps. In mirror mode the same branch fetches from the mirrored address.
- R10: In mirror mode halted never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 16 | Instruction word fetched from iaddr |
| iaddr | output | IADDR_W | Instruction fetch address |
| din | input | 16 | Data read word at daddr |
| daddr | output | DADDR_W | Data address, low bits of A |
| dout | output | 16 | Data write word (ALU result) |
| dwe | output | 1 | Data write enable |
| halted | output | 1 | Core stopped by overrun trap |

## Verification
The bench builds two copies side by side with a 6-bit fetch address, one in each overrun policy, and drives both with the same instruction stream. With the narrow fetch address, running off the end takes only 64 words, so the wrap, the trap entry, the frozen state while halted and the release by reset can all be seen directly. The data address stays at 15 bits. All 64 ALU control codes are swept against both operand sources with several operand pairs. Every branch-condition mask is tried on negative, zero and positive results.

// File: rtl/core_pkg.sv
package core_pkg;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned IMM_W  = 15;

  typedef struct packed {
    logic zx;
    logic nx;
    logic zy;
    logic ny;
    logic fadd;
    logic nout;
  } alu_ctl_t;

  typedef struct packed {
    logic             is_comp;
    logic             use_mem;
    alu_ctl_t         ctl;
    logic             wr_a;
    logic             wr_d;
    logic             wr_m;
    logic [2:0]       jmp;
    logic [IMM_W-1:0] imm;
    logic             all_ones;
  } dec_t;

  // branch condition: jmp = {negative, zero, positive}
  function automatic logic jump_hit(input logic [2:0] jb, input logic zero, input logic neg);
    logic pos;
    pos = ~zero & ~neg;
    return (jb[2] & neg) | (jb[1] & zero) | (jb[0] & pos);
  endfunction

endpackage

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output dec_t              dec
);

  always_comb begin
    dec.is_comp  = instr[15];
    dec.use_mem  = instr[12];
    dec.ctl      = alu_ctl_t'(instr[11:6]);
    dec.wr_a     = instr[5];
    dec.wr_d     = instr[4];
    dec.wr_m     = instr[3];
    dec.jmp      = instr[2:0];
    dec.imm      = instr[IMM_W-1:0];
    dec.all_ones = &instr;
  end

endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  alu_ctl_t     ctl,
  output logic [W-1:0] res,
  output logic         zero,
  output logic         neg
);

  function automatic logic [W-1:0] prep(input logic [W-1:0] v, input logic clr, input logic inv);
    logic [W-1:0] t;
    t = clr ? '0 : v;
    return inv ? ~t : t;
  endfunction

  function automatic logic [W-1:0] combine(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic add, input logic inv);
    logic [W-1:0] t;
    t = add ? (a + b) : (a & b);
    return inv ? ~t : t;
  endfunction

  logic [W-1:0] xs, ys;

  assign xs   = prep(x, ctl.zx, ctl.nx);
  assign ys   = prep(y, ctl.zy, ctl.ny);
  assign res  = combine(xs, ys, ctl.fadd, ctl.nout);
  assign zero = (res == '0);
  assign neg  = res[W-1];

endmodule

// File: rtl/core_pc.sv
module core_pc #(
  parameter int PC_W = 16,
  parameter bit TRAP = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            jump_take,
  input  logic [PC_W-1:0] jump_tgt,
  output logic [PC_W-1:0] pc_q,
  output logic            halted
);

  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] pc_nxt;
  logic            trap_q;

  assign pc_inc = pc_q + PC_W'(1);
  assign pc_nxt = jump_take ? jump_tgt : pc_inc;
  assign halted = trap_q;

  always_ff @(posedge clk) begin
    if (rst)          pc_q <= '0;
    else if (!trap_q) pc_q <= pc_nxt;
  end

  generate
    if (TRAP) begin : g_trap
      always_ff @(posedge clk) begin
        if (rst)                            trap_q <= 1'b0;
        else if (!trap_q && pc_nxt[PC_W-1]) trap_q <= 1'b1;
      end

      a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        trap_q |=> (trap_q && $stable(pc_q)));

      a_r8_enter: assert property (@(posedge clk) disable iff (rst)
        (!trap_q && pc_nxt[PC_W-1]) |=> trap_q);
    end else begin : g_mirror
      assign trap_q = 1'b0;

      a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
        ((&pc_q[PC_W-2:0]) && !jump_take) |=> (pc_q[PC_W-2:0] == '0));
    end
  endgenerate

  a_r1_reset: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && !halted));

  a_r5_taken: assert property (@(posedge clk) disable iff (rst)
    (!halted && jump_take) |=> (pc_q == $past(jump_tgt)));

  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    (!halted && !jump_take) |=> (pc_q == $past(pc_q) + PC_W'(1)));

endmodule

// File: rtl/tiny_core.sv
module tiny_core
  import core_pkg::*;
#(
  parameter int IADDR_W         = 15,
  parameter int DADDR_W         = 15,
  parameter bit TRAP_ON_OVERRUN = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [WORD_W-1:0]   instr,
  output logic [IADDR_W-1:0]  iaddr,
  input  logic [WORD_W-1:0]   din,
  output logic [DADDR_W-1:0]  daddr,
  output logic [WORD_W-1:0]   dout,
  output logic                dwe,
  output logic                halted
);

  localparam int PC_W = IADDR_W + 1;

  dec_t              dec;
  logic [WORD_W-1:0] a_q, d_q;
  logic [WORD_W-1:0] alu_y, alu_res;
  logic              alu_zero, alu_neg;
  logic              jump_take;
  logic              run;
  logic [PC_W-1:0]   pc_q;

  core_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  assign alu_y = dec.use_mem ? din : a_q;

  core_alu #(.W(WORD_W)) u_alu (
    .x    (d_q),
    .y    (alu_y),
    .ctl  (dec.ctl),
    .res  (alu_res),
    .zero (alu_zero),
    .neg  (alu_neg)
  );

  assign jump_take = dec.is_comp & jump_hit(dec.jmp, alu_zero, alu_neg);

  core_pc #(.PC_W(PC_W), .TRAP(TRAP_ON_OVERRUN)) u_pc (
    .clk       (clk),
    .rst       (rst),
    .jump_take (jump_take),
    .jump_tgt  (a_q[PC_W-1:0]),
    .pc_q      (pc_q),
    .halted    (halted)
  );

  assign run = ~halted;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      d_q <= '0;
    end else if (run) begin
      if (!dec.is_comp) begin
        a_q <= {1'b0, dec.imm};
      end else begin
        if (dec.wr_a) a_q <= alu_res;
        if (dec.wr_d) d_q <= alu_res;
      end
    end
  end

  assign iaddr = pc_q[IADDR_W-1:0];
  assign daddr = a_q[DADDR_W-1:0];
  assign dout  = alu_res;
  assign dwe   = run & dec.is_comp & dec.wr_m;

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    (!halted && !instr[15]) |=> (a_q == {1'b0, $past(instr[14:0])}));

  a_r2_nowrite: assert property (@(posedge clk) disable iff (rst)
    !instr[15] |-> !dwe);

  a_r4_dreg: assert property (@(posedge clk) disable iff (rst)
    (!halted && instr[15] && instr[4]) |=> (d_q == $past(alu_res)));

  a_r6_allones: assert property (@(posedge clk) disable iff (rst)
    (!halted && dec.all_ones) |=> (a_q == 16'd1 && d_q == 16'd1));

  a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
    halted |-> !dwe);

endmodule

// File: tb/sim_tiny_core.sv
module sim_tiny_core;

  localparam int CLK_PERIOD = 10;
  localparam int IW = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = 16'h0000;
  logic [15:0] din = 16'h0000;

  logic [IW-1:0] iaddr0, iaddr1;
  logic [14:0]   daddr0, daddr1;
  logic [15:0]   dout0, dout1;
  logic          dwe0, dwe1, halt0, halt1;

  int n_vec = 0;
  int n_bad = 0;

  logic        c_dwe0, c_dwe1;
  logic [14:0] c_daddr0;
  logic [15:0] c_dout0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tiny_core #(.IADDR_W(IW), .DADDR_W(15), .TRAP_ON_OVERRUN(1'b0)) u0 (
    .clk(clk), .rst(rst), .instr(instr), .iaddr(iaddr0), .din(din),
    .daddr(daddr0), .dout(dout0), .dwe(dwe0), .halted(halt0));

  tiny_core #(.IADDR_W(IW), .DADDR_W(15), .TRAP_ON_OVERRUN(1'b1)) u1 (
    .clk(clk), .rst(rst), .instr(instr), .iaddr(iaddr1), .din(din),
    .daddr(daddr1), .dout(dout1), .dwe(dwe1), .halted(halt1));

  function automatic logic [15:0] comp(input logic a, input logic [5:0] c,
                                       input logic [2:0] d, input logic [2:0] j);
    return {3'b111, a, c, d, j};
  endfunction

  // reference ALU written arithmetically: inversion as 0xFFFF minus value
  function automatic logic [15:0] ref_alu(input logic [15:0] x, input logic [15:0] y,
                                          input logic [5:0] c);
    logic [15:0] xv, yv, r;
    xv = c[5] ? 16'd0 : x;
    if (c[4]) xv = 16'hFFFF - xv;
    yv = c[3] ? 16'd0 : y;
    if (c[2]) yv = 16'hFFFF - yv;
    r = c[1] ? 16'(xv + yv) : (xv & yv);
    if (c[0]) r = 16'hFFFF - r;
    return r;
  endfunction

  localparam logic [5:0] C_Y    = 6'b110000;
  localparam logic [5:0] C_X    = 6'b001100;
  localparam logic [5:0] C_ZERO = 6'b101010;
  localparam logic [5:0] C_ADD  = 6'b000010;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] i, input logic [15:0] m);
    instr = i;
    din   = m;
    @(negedge clk);
    c_dwe0   = dwe0;
    c_dwe1   = dwe1;
    c_daddr0 = daddr0;
    c_dout0  = dout0;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst   = 1'b1;
    instr = 16'h0000;
    @(posedge clk);
    @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  logic [15:0] px [5];
  logic [15:0] py [5];

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    px[0] = 16'h1234; py[0] = 16'h00F0;
    px[1] = 16'hFFFF; py[1] = 16'h0001;
    px[2] = 16'h8000; py[2] = 16'h7FFF;
    px[3] = 16'h0000; py[3] = 16'h0000;
    px[4] = 16'h5A5A; py[4] = 16'hA5A5;

    // R1 reset state
    do_reset();
    @(negedge clk);
    chk("R1 iaddr mirror", iaddr0, 0);
    chk("R1 iaddr trap", iaddr1, 0);
    chk("R1 halted", {halt0, halt1}, 0);
    chk("R1 dwe", {dwe0, dwe1}, 0);
    @(posedge clk); #1;
    do_reset();
    issue(comp(0, C_X, 3'b001, 3'b000), 16'h0000);
    chk("R1 A and D cleared", {c_dwe0, 1'b0, c_daddr0, c_dout0}, {1'b1, 1'b0, 15'd0, 16'd0});

    // R3 / R4 ALU sweep over all control codes, both operand sources
    for (int p = 0; p < 5; p++) begin
      for (int c = 0; c < 64; c++) begin
        issue(comp(1, C_Y, 3'b010, 3'b000), px[p]);
        issue(comp(1, C_Y, 3'b100, 3'b000), py[p]);
        issue(comp(0, c[5:0], 3'b001, 3'b000), 16'h0000);
        chk("R3 R4 alu y=A", {c_dwe0, c_daddr0, c_dout0},
            {1'b1, py[p][14:0], ref_alu(px[p], py[p], c[5:0])});
        issue(comp(1, c[5:0], 3'b001, 3'b000), ~py[p]);
        chk("R3 R4 alu y=mem", {c_dwe0, c_daddr0, c_dout0},
            {1'b1, py[p][14:0], ref_alu(px[p], ~py[p], c[5:0])});
      end
    end

    // R4 A and D destinations together, no memory write
    issue(comp(1, C_Y, 3'b010, 3'b000), 16'h0123);
    issue(comp(1, C_Y, 3'b100, 3'b000), 16'h0456);
    issue(comp(0, C_ADD, 3'b110, 3'b000), 16'h0000);
    chk("R4 no M dest no write", c_dwe0, 0);
    issue(comp(0, C_X, 3'b001, 3'b000), 16'h0000);
    chk("R4 A and D written", {c_daddr0, c_dout0}, {15'h0579, 16'h0579});

    // R2 address load keeps D, no write, PC advances
    issue(comp(1, C_Y, 3'b010, 3'b000), 16'h1357);
    begin
      logic [IW-1:0] pre;
      pre = iaddr0;
      issue(16'h2A5A, 16'h0000);
      chk("R2 load no write", c_dwe0, 0);
      chk("R2 pc step", iaddr0, IW'(pre + 1));
    end
    issue(comp(0, C_X, 3'b001, 3'b000), 16'h0000);
    chk("R2 A loaded D kept", {c_daddr0, c_dout0}, {15'h2A5A, 16'h1357});
    issue(16'h0000, 16'h0000);
    chk("R2 zero word no write", c_dwe0, 0);
    issue(comp(0, C_X, 3'b001, 3'b000), 16'h0000);
    chk("R2 zero word loads 0", {c_daddr0, c_dout0}, {15'h0000, 16'h1357});

    // R5 every jump mask on negative, zero, positive
    for (int v = 0; v < 3; v++) begin
      for (int j = 0; j < 8; j++) begin
        logic [15:0] dv;
        logic [IW-1:0] tgt, pre, ex;
        logic take;
        dv  = (v == 0) ? 16'hFFF0 : ((v == 1) ? 16'h0000 : 16'h0003);
        tgt = IW'(40 + j);
        issue(comp(1, C_Y, 3'b010, 3'b000), dv);
        issue({10'd0, tgt}, 16'h0000);
        pre  = iaddr0;
        take = (j[2] && $signed(dv) < 0) || (j[1] && dv == 0) || (j[0] && $signed(dv) > 0);
        ex   = take ? tgt : IW'(pre + 1);
        issue(comp(0, C_X, 3'b000, j[2:0]), 16'h0000);
        chk("R5 jump mask", {j[2:0], dv, iaddr0}, {j[2:0], dv, ex});
      end
    end

    // R5 self loop idiom
    begin
      logic [IW-1:0] here;
      here = iaddr0;
      for (int k = 0; k < 3; k++) begin
        issue({10'd0, here}, 16'h0000);
        issue(comp(0, C_ZERO, 3'b000, 3'b111), 16'h0000);
        chk("R5 self loop", iaddr0, here);
      end
    end

    // R6 all-ones word
    issue(16'h0005, 16'h0000);
    issue(16'hFFFF, 16'h0000);
    chk("R6 all ones write", {c_dwe0, c_daddr0, c_dout0}, {1'b1, 15'd5, 16'd1});
    chk("R6 all ones jump", iaddr0, 5);
    issue(comp(0, C_X, 3'b001, 3'b000), 16'h0000);
    chk("R6 A and D are one", {c_daddr0, c_dout0}, {15'd1, 16'd1});

    // R7 / R8 / R10 run off the end
    do_reset();
    for (int k = 0; k < 63; k++) begin
      issue(16'h0000, 16'h0000);
    end
    chk("R7 last word", iaddr0, 63);
    chk("R8 not yet halted", {halt1, iaddr1}, {1'b0, 6'd63});
    issue(16'h0000, 16'h0000);
    chk("R7 mirror wraps to 0", {halt0, iaddr0}, {1'b0, 6'd0});
    chk("R8 trap raised", {halt1, iaddr1}, {1'b1, 6'd0});
    issue(comp(1, C_Y, 3'b010, 3'b000), 16'h00AA);
    issue(16'hFFFF, 16'h0000);
    chk("R8 halted no write", c_dwe1, 0);
    chk("R10 mirror still runs", {halt0, c_dwe0}, {1'b0, 1'b1});
    issue(comp(0, C_X, 3'b001, 3'b000), 16'h0000);
    chk("R8 halted frozen", {halt1, iaddr1, c_dwe1}, {1'b1, 6'd0, 1'b0});
    do_reset();
    @(negedge clk);
    chk("R1 reset clears trap", {halt1, iaddr1}, {1'b0, 6'd0});
    @(posedge clk); #1;

    // R9 branch to address with top PC bit set
    do_reset();
    issue(16'h0040, 16'h0000);
    issue(comp(0, C_ZERO, 3'b000, 3'b111), 16'h0000);
    chk("R9 trap on jump", {halt1, iaddr1}, {1'b1, 6'd0});
    chk("R9 mirror on jump", {halt0, iaddr0}, {1'b0, 6'd0});
    issue(16'h0000, 16'h0000);
    chk("R9 trap holds", {halt1, iaddr1}, {1'b1, 6'd0});
    chk("R10 mirror advances", {halt0, iaddr0}, {1'b0, 6'd1});

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule